// File: doc/BRIEF.md
# Read-Ordered Clearing Packet Statistics Bank

This block keeps packet statistics for one transmit and one receive path. Each path has a saturating 32-bit count of good packets and a saturating 16-bit count of errored packets. Software reads them through a 16-bit register read port. The six statistics registers form two groups of three, one group per direction. In each group the first register holds the low half of the good count, the second holds the high half, and the third holds the error count.

A group's clearing is driven by the order of the reads. Reading a group's first register freezes that group, so the low half, the high half and the error count all come from the same instant. If the next two reads of the group hit its second register and then its third, in that order, the group clears. Any other read of the group while the sequence is open cancels the clear and releases the group with its counts intact.

Packets that arrive while a group is frozen are not lost. They collect in a holding count and are folded in when the freeze ends. After a clear they become the new count, and after a cancelled sequence they are added to the old one. The read port has no back-pressure. A read request is accepted in every cycle, and its data returns exactly one cycle later, marked by a valid pulse.

Top module: `pkt_stat_bank`

## Requirements
- R1: The registers sit at six consecutive addresses starting at `BASE_ADDR` (default 0x12B). Offsets 0, 1 and 2 return the transmit good count bits [15:0], the transmit good count bits [31:16] and the transmit error count. Offsets 3, 4 and 5 return the same three fields for receive. A read with `rd_en` high returns its data on `rd_data` with `rd_valid` high in the next cycle. An address outside the six returns 0.
- R2: A cycle with `tx_pkt` high and `tx_err` low adds one to the transmit good count. A cycle with `tx_pkt` and `tx_err` both high adds one to the transmit error count. `rx_pkt` and `rx_err` act the same way on the receive counts. Both directions can count in the same cycle.
- R3: A read of a group's first register while that group is idle freezes the group. Until the freeze ends, reads of that group return the values the counts had in the cycle of that first read.
- R4: When the group's second register and then its third register are the next two reads of that group after the first, the third read returns the frozen value. The group then clears, and its counts hold only the packets that arrived during the freeze (0 if none arrived).
- R5: Any other read of a group while its sequence is open, including a repeated read of its first register, ends the freeze without clearing. The sequence 1,2,1,2,3 therefore leaves the counts intact.
- R6: Packets that arrive during a freeze, including the cycle that starts it and the cycle that ends it, are added to the counts when the freeze ends, whether the group was cleared or not.
- R7: Every count saturates at its all-ones value and does not wrap.
- R8: Reads of addresses outside the six registers, and reads of the other group, neither advance nor cancel a group's open sequence.
- R9: A read of a group's second or third register while the group is idle does not freeze the group. Such a read returns the live count.
- R10: After reset every count is 0 and `rd_valid` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_pkt | input | 1 | One transmit packet completed this cycle |
| tx_err | input | 1 | Qualifies `tx_pkt`: the packet was errored |
| rx_pkt | input | 1 | One receive packet completed this cycle |
| rx_err | input | 1 | Qualifies `rx_pkt`: the packet was errored |
| rd_en | input | 1 | Register read request, accepted every cycle |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Read data, valid one cycle after the request |
| rd_valid | output | 1 | `rd_data` carries the result of the previous cycle's read |

## Verification
Suppose the sequence tracker is left in the wrong state. If it sticks frozen, the next read of the group returns stale values and packets appear to vanish until some later read releases them. If it fails to advance, the read of the group's first register after an in-order sequence returns the old count instead of zero. Either fault shows on `rd_data` within one read of the sequence that should have cleared or released the group. A holding count that is lost or added twice shows as an off-by-N count at the first read after the freeze ends. Because the scenarios use distinct packet counts per phase, such an error maps back to a single step.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;

  // Register groups: transmit is group 0, receive is group 1.
  localparam int GRPS         = 2;
  localparam int REGS_PER_GRP = 3;
  localparam int NREGS        = GRPS * REGS_PER_GRP;

  // Read-order tracker state for one group.
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ONE  = 2'd1,
    SQ_TWO  = 2'd2
  } seq_st_e;

  // Add with clamp at maxv; operands are zero-extended by the caller.
  function automatic logic [31:0] sat_add32(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [31:0] maxv);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > {1'b0, maxv}) ? maxv : s[31:0];
  endfunction

endpackage

// File: rtl/pkt_stat_ctr.sv
module pkt_stat_ctr
  import pkt_stat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HOLD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev,
  input  logic                  ev_err,
  input  logic                  hold,
  input  logic                  rel_clear,
  input  logic                  rel_merge,
  output logic [2*DATA_W-1:0]   good_q,
  output logic [DATA_W-1:0]     err_q
);
  localparam int GOOD_W = 2 * DATA_W;
  localparam logic [31:0] G_MAX = 32'((64'd1 << GOOD_W) - 64'd1);
  localparam logic [31:0] E_MAX = 32'((64'd1 << DATA_W) - 64'd1);
  localparam logic [31:0] H_MAX = 32'((64'd1 << HOLD_W) - 64'd1);

  logic [HOLD_W-1:0] hg_q, he_q, hg_nx, he_nx;
  logic              inc_g, inc_e;
  logic [GOOD_W-1:0] g_live, g_merge, g_fresh;
  logic [DATA_W-1:0] e_live, e_merge, e_fresh;

  always_comb begin
    inc_g   = ev & ~ev_err;
    inc_e   = ev & ev_err;
    hg_nx   = HOLD_W'(sat_add32(32'(hg_q), 32'(inc_g), H_MAX));
    he_nx   = HOLD_W'(sat_add32(32'(he_q), 32'(inc_e), H_MAX));
    g_live  = GOOD_W'(sat_add32(32'(good_q), 32'(inc_g), G_MAX));
    e_live  = DATA_W'(sat_add32(32'(err_q), 32'(inc_e), E_MAX));
    g_merge = GOOD_W'(sat_add32(32'(good_q), 32'(hg_nx), G_MAX));
    e_merge = DATA_W'(sat_add32(32'(err_q), 32'(he_nx), E_MAX));
    g_fresh = GOOD_W'(sat_add32(32'd0, 32'(hg_nx), G_MAX));
    e_fresh = DATA_W'(sat_add32(32'd0, 32'(he_nx), E_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      err_q  <= '0;
      hg_q   <= '0;
      he_q   <= '0;
    end else if (rel_clear) begin
      good_q <= g_fresh;
      err_q  <= e_fresh;
      hg_q   <= '0;
      he_q   <= '0;
    end else if (rel_merge) begin
      good_q <= g_merge;
      err_q  <= e_merge;
      hg_q   <= '0;
      he_q   <= '0;
    end else if (hold) begin
      hg_q <= hg_nx;
      he_q <= he_nx;
    end else begin
      good_q <= g_live;
      err_q  <= e_live;
    end
  end

endmodule

// File: rtl/pkt_stat_seq.sv
module pkt_stat_seq
  import pkt_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [1:0] idx,
  output logic       frozen,
  output logic       start,
  output logic       rel_clear,
  output logic       rel_merge
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    start     = 1'b0;
    rel_clear = 1'b0;
    rel_merge = 1'b0;
    if (hit) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (idx == 2'd0) begin
            start = 1'b1;
            st_d  = SQ_ONE;
          end
        end
        SQ_ONE: begin
          if (idx == 2'd1) begin
            st_d = SQ_TWO;
          end else begin
            rel_merge = 1'b1;
            st_d      = SQ_IDLE;
          end
        end
        SQ_TWO: begin
          if (idx == 2'd2) rel_clear = 1'b1;
          else             rel_merge = 1'b1;
          st_d = SQ_IDLE;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  assign frozen = (st_q != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/pkt_stat_bank.sv
module pkt_stat_bank
  import pkt_stat_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h12B,
  parameter int                DATA_W    = 16,
  parameter int                HOLD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_pkt,
  input  logic              tx_err,
  input  logic              rx_pkt,
  input  logic              rx_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int GOOD_W = 2 * DATA_W;

  logic [ADDR_W-1:0] off;
  logic              in_rng;
  logic              sel_grp;
  logic [1:0]        sel_idx;
  logic [DATA_W-1:0] rd_mux;

  logic              ev_s   [GRPS];
  logic              er_s   [GRPS];
  logic [GOOD_W-1:0] cnt_good [GRPS];
  logic [DATA_W-1:0] cnt_err  [GRPS];
  logic [GRPS-1:0]   grp_hit, grp_frz, grp_start, grp_clr, grp_abt;

  assign ev_s[0] = tx_pkt;
  assign er_s[0] = tx_err;
  assign ev_s[1] = rx_pkt;
  assign er_s[1] = rx_err;

  // Address decode into group and position within the group.
  assign off     = rd_addr - BASE_ADDR;
  assign in_rng  = (rd_addr >= BASE_ADDR) && (off < ADDR_W'(NREGS));
  assign sel_grp = (off >= ADDR_W'(REGS_PER_GRP));
  assign sel_idx = sel_grp ? 2'(off - ADDR_W'(REGS_PER_GRP)) : 2'(off);

  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    assign grp_hit[g] = rd_en && in_rng && (sel_grp == 1'(g));

    pkt_stat_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (grp_hit[g]),
      .idx       (sel_idx),
      .frozen    (grp_frz[g]),
      .start     (grp_start[g]),
      .rel_clear (grp_clr[g]),
      .rel_merge (grp_abt[g])
    );

    pkt_stat_ctr #(
      .DATA_W (DATA_W),
      .HOLD_W (HOLD_W)
    ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev_s[g]),
      .ev_err    (er_s[g]),
      .hold      (grp_frz[g] | grp_start[g]),
      .rel_clear (grp_clr[g]),
      .rel_merge (grp_abt[g]),
      .good_q    (cnt_good[g]),
      .err_q     (cnt_err[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (in_rng) begin
      unique case (sel_idx)
        2'd0:    rd_mux = cnt_good[sel_grp][DATA_W-1:0];
        2'd1:    rd_mux = cnt_good[sel_grp][GOOD_W-1:DATA_W];
        default: rd_mux = cnt_err[sel_grp];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/pkt_stat_bank_chk.sv
module pkt_stat_bank_chk #(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h12B,
  parameter int                DATA_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic                rd_valid,
  input logic [1:0]          frz,
  input logic [1:0]          clr,
  input logic [1:0]          abt,
  input logic [2*DATA_W-1:0] tx_good,
  input logic [DATA_W-1:0]   tx_errc
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(5);

  logic oor_rd;
  assign oor_rd = rd_en && ((rd_addr < BASE_ADDR) || (rd_addr > LAST_ADDR));

  p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rd_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  p_freeze_onset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == BASE_ADDR && !frz[0]) |=> frz[0]);

  p_frozen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz[0] && !clr[0] && !abt[0]) |=> ($stable(tx_good) && $stable(tx_errc)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] || abt[0]) |=> !frz[0]);

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_errc == '1 && !clr[0]) |=> tx_errc == '1);

  p_oor_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oor_rd |=> $stable(frz));

endmodule

bind pkt_stat_bank pkt_stat_bank_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .DATA_W    (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_valid (rd_valid),
  .frz      (grp_frz),
  .clr      (grp_clr),
  .abt      (grp_abt),
  .tx_good  (cnt_good[0]),
  .tx_errc  (cnt_err[0])
);

// File: tb/pkt_stat_bank_test.sv
`timescale 1ns/1ps
module pkt_stat_bank_test;
  localparam logic [11:0] B = 12'h12B;
  localparam logic [11:0] T0 = B, T1 = B + 12'd1, T2 = B + 12'd2;
  localparam logic [11:0] X0 = B + 12'd3, X1 = B + 12'd4, X2 = B + 12'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_pkt = 1'b0, tx_err = 1'b0, rx_pkt = 1'b0, rx_err = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pkt_stat_bank uut (
    .clk(clk), .rst_n(rst_n),
    .tx_pkt(tx_pkt), .tx_err(tx_err), .rx_pkt(rx_pkt), .rx_err(rx_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: issue one read and push its expected data.
  task automatic rd(input logic [11:0] a, input int exp, input string tag);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pk(input bit t, input bit te, input bit r, input bit re, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_pkt = t; tx_err = te; rx_pkt = r; rx_err = re;
    end
    @(negedge clk);
    tx_pkt = 1'b0; tx_err = 1'b0; rx_pkt = 1'b0; rx_err = 1'b0;
  endtask

  // Monitor: compare each returned read with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected rd_valid", 1, 0);
      end else begin
        chk(tag_q.pop_front(), int'(rd_data), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 rd_valid after reset", int'(rd_valid), 0);
    chk("R10 rd_data after reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: all counts zero; full in-order reads of both groups
    rd(T0, 0, "R10 tx lo"); rd(T1, 0, "R10 tx hi"); rd(T2, 0, "R10 tx err");
    rd(X0, 0, "R10 rx lo"); rd(X1, 0, "R10 rx hi"); rd(X2, 0, "R10 rx err");

    // R2 counting, R4 in-order clear
    pk(1, 0, 0, 0, 5); pk(1, 1, 0, 0, 2); pk(0, 0, 1, 0, 3); pk(0, 0, 1, 1, 1);
    rd(T0, 5, "R2 tx good"); rd(T1, 0, "R1 tx hi"); rd(T2, 2, "R2 tx err");
    rd(T0, 0, "R4 tx lo cleared"); rd(T1, 0, "R4 tx hi cleared"); rd(T2, 0, "R4 tx err cleared");

    // R3 freeze, R6 held events become count after clear
    rd(X0, 3, "R2 rx good");
    pk(0, 0, 1, 0, 4); pk(0, 0, 1, 1, 2);
    rd(X1, 0, "R3 rx hi frozen"); rd(X2, 1, "R3 rx err frozen");
    rd(X0, 4, "R6 rx held good"); rd(X1, 0, "R6 rx hi"); rd(X2, 2, "R6 rx held err");

    // R5: sequence 1,2,1,2,3 does not clear
    pk(1, 0, 0, 0, 7);
    rd(T0, 7, "R5 first"); rd(T1, 0, "R5 second"); rd(T0, 7, "R5 repeat first");
    rd(T1, 0, "R5 idle hi"); rd(T2, 0, "R5 idle err");
    rd(T0, 7, "R5 not cleared"); rd(T1, 0, "R5 hi"); rd(T2, 0, "R5 err");

    // R6: held events merged after an aborted sequence
    pk(1, 0, 0, 0, 9);
    rd(T0, 9, "R6 lo before");
    pk(1, 0, 0, 0, 3); pk(1, 1, 0, 0, 1);
    rd(T2, 0, "R3 frozen err on abort");
    rd(T2, 1, "R6 merged err");
    rd(T0, 12, "R6 merged good"); rd(T1, 0, "R6 hi"); rd(T2, 1, "R6 err at clear");

    // R8: foreign reads between sequence steps
    pk(1, 0, 0, 0, 2);
    rd(T0, 2, "R8 start");
    rd(B + 12'd6, 0, "R1 above range"); rd(B - 12'd1, 0, "R1 below range");
    rd(X0, 0, "R8 other group");
    rd(T1, 0, "R8 hi"); rd(T2, 0, "R8 err");
    rd(T0, 0, "R8 cleared despite foreign reads"); rd(T1, 0, "R8 hi"); rd(T2, 0, "R8 err");
    rd(X1, 0, "R8 rx hi"); rd(X2, 0, "R8 rx err");

    // R9: idle reads of later registers do not freeze
    pk(1, 1, 0, 0, 1);
    rd(T2, 1, "R9 idle err");
    pk(1, 1, 0, 0, 1);
    rd(T2, 2, "R9 live err"); rd(T1, 0, "R9 idle hi");
    rd(T0, 0, "R9 lo"); rd(T1, 0, "R9 hi"); rd(T2, 2, "R9 err at clear");

    // R7: error count saturates
    pk(1, 1, 0, 0, 65540);
    rd(T2, 65535, "R7 saturated err");
    rd(T0, 0, "R7 lo"); rd(T1, 0, "R7 hi"); rd(T2, 65535, "R7 err at clear");
    rd(T2, 0, "R7 err after clear");

    // R2: both directions in the same cycle
    pk(1, 0, 1, 0, 6);
    rd(T0, 6, "R2 tx concurrent"); rd(X0, 6, "R2 rx concurrent");

    repeat (3) @(negedge clk);
    chk("R1 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule